// File: doc/BRIEF.md
# Filtered Performance Event Counter

This block is one performance monitoring counter together with its configuration register. In every clock cycle it receives a small event value from an event source. Depending on a programmable threshold, it either adds that value to a 32-bit count or adds one when the value is above the threshold. Counting is qualified by three things: the current privilege level, checked against a per-level mask; the current instruction-set mode, checked against an active-low mask; and either a user or a privileged monitor enable, chosen by a mode bit in the configuration.

When the count carries out of its top bit, the block can raise a one-cycle interrupt pulse and set a freeze bit that stops further counting until software clears it. Independently of that, it can pulse an external strobe on every wrap. Software loads the counter through a write port. Reads of the counter are hidden from non-privileged levels when the counter is configured as privileged.

Top module: `pmc_counter`

## Requirements
- R1: After a synchronous reset the count, configuration, freeze bit, interrupt pulse and strobe pulse are all zero.
- R2: Configuration bits 3:0 form a level mask. An event is counted only when the bit indexed by `cur_lvl` is set. A mask of zero never counts.
- R3: Configuration bits 25:24 form an active-low mode mask. Clear bit 24 allows counting while `isa_mode` is 0, and clear bit 25 allows counting while `isa_mode` is 1. The value 11 never counts.
- R4: Configuration bit 6 chooses the gating enable. When it is 0, `user_en` gates counting. When it is 1, `priv_en` gates counting.
- R5: When the threshold field (bits 22:20, or bits 21:20 when THR_W is 2) is zero, each counted cycle adds the zero-extended `evt_val`.
- R6: When the threshold is non-zero, a counted cycle adds one if `evt_val` is strictly greater than the threshold, and adds nothing otherwise.
- R7: A carry out of bit 31 with configuration bit 5 set gives a single one-cycle `ovf_irq` in the cycle after the wrap and sets `freeze`. With bit 5 clear, neither `ovf_irq` nor `freeze` changes.
- R8: A carry out of bit 31 with configuration bit 4 set gives a one-cycle `ext_strobe` in the cycle after the wrap, whatever bit 5 holds.
- R9: While `freeze` is 1 the count holds. `frz_we` writes `frz_wdata` into the freeze bit. When a freeze write and an interrupting overflow fall in the same cycle, the overflow wins and the bit becomes 1.
- R10: `cnt_we` loads `cnt_wdata` into the count at the next edge, and this load takes priority over counting in that cycle.
- R11: When configuration bit 6 is 1 and `cur_lvl` is non-zero, `cnt_rdata` reads zero and `rd_fault` equals `cnt_re`. Otherwise `cnt_rdata` shows the count and `rd_fault` is 0.
- R12: `cfg_rdata` returns the stored fields at their write positions: bits 3:0, 6:4, 14:8, the threshold field and 25:24. All other bits read zero, and a configuration write takes effect from the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Stored configuration |
| cnt_we | input | 1 | Counter load strobe |
| cnt_wdata | input | CNT_W | Counter load value |
| cnt_re | input | 1 | Counter read request |
| cnt_rdata | output | CNT_W | Counter read data, protected |
| rd_fault | output | 1 | Read denied at current level |
| frz_we | input | 1 | Freeze bit write strobe |
| frz_wdata | input | 1 | Freeze bit write value |
| evt_val | input | EVT_W | Event value this cycle |
| cur_lvl | input | 2 | Current privilege level |
| isa_mode | input | 1 | Current instruction-set mode |
| user_en | input | 1 | User monitor enable |
| priv_en | input | 1 | Privileged monitor enable |
| freeze | output | 1 | Freeze bit |
| ovf_irq | output | 1 | Overflow interrupt pulse |
| ext_strobe | output | 1 | External wrap strobe pulse |

## Verification
Summing mode is driven with every event value from 0 to 15, so that a dropped or shifted bit of the zero extension shows up in the count. Threshold mode is driven with values equal to, one above and far below the threshold, which separates a strict compare from a non-strict one and separates summing from incrementing. The gating inputs are swept through every level, every mode-mask code in both modes, and all four enable combinations under each setting of the mode bit. Wraps are forced from preloaded values with the interrupt enable and the strobe enable set alone and together, including a wrap that lands in the same cycle as a software clear of the freeze bit.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

    localparam int CFG_W     = 32;
    localparam int LVL_N     = 4;
    localparam int LVL_W     = 2;
    localparam int THR_MAX_W = 3;
    localparam int SEL_W     = 7;

    typedef struct packed {
        logic [1:0]           isa_mask;
        logic [THR_MAX_W-1:0] thr;
        logic [SEL_W-1:0]     evt_sel;
        logic                 priv_mode;
        logic                 irq_en;
        logic                 strobe_en;
        logic [LVL_N-1:0]     lvl_mask;
    } pmc_cfg_t;

    function automatic logic [CFG_W-1:0] pack_cfg(pmc_cfg_t c);
        logic [CFG_W-1:0] w;
        w        = '0;
        w[3:0]   = c.lvl_mask;
        w[4]     = c.strobe_en;
        w[5]     = c.irq_en;
        w[6]     = c.priv_mode;
        w[14:8]  = c.evt_sel;
        w[22:20] = c.thr;
        w[25:24] = c.isa_mask;
        return w;
    endfunction

    // Active-low mode mask: bit 0 guards mode 0, bit 1 guards mode 1.
    function automatic logic isa_allows(logic [1:0] m, logic isa);
        return isa ? ~m[1] : ~m[0];
    endfunction

    function automatic logic lvl_allows(logic [LVL_N-1:0] m, logic [LVL_W-1:0] lvl);
        return m[lvl];
    endfunction

endpackage

// File: rtl/pmc_cfg_reg.sv
module pmc_cfg_reg
    import pmc_pkg::*;
#(
    parameter int THR_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [CFG_W-1:0] wdata,
    output pmc_cfg_t         cfg_o
);

    logic [THR_MAX_W-1:0] thr_field;
    pmc_cfg_t             nxt;
    logic                 unused_bits;

    generate
        if (THR_W >= THR_MAX_W) begin : g_wide_thr
            assign thr_field = wdata[22:20];
        end else begin : g_narrow_thr
            assign thr_field = {1'b0, wdata[21:20]};
        end
    endgenerate

    assign unused_bits = ^{wdata[31:26], wdata[23], wdata[22], wdata[19:15], wdata[7]};

    always_comb begin
        nxt.lvl_mask  = wdata[3:0];
        nxt.strobe_en = wdata[4];
        nxt.irq_en    = wdata[5];
        nxt.priv_mode = wdata[6];
        nxt.evt_sel   = wdata[14:8];
        nxt.thr       = thr_field;
        nxt.isa_mask  = wdata[25:24];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_o <= '0;
        end else if (we) begin
            cfg_o <= nxt;
        end
    end

endmodule

// File: rtl/pmc_gate.sv
module pmc_gate
    import pmc_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int EVT_W = 4
) (
    input  logic [LVL_N-1:0]     lvl_mask,
    input  logic [1:0]           isa_mask,
    input  logic                 priv_mode,
    input  logic [THR_MAX_W-1:0] thr,
    input  logic [LVL_W-1:0]     cur_lvl,
    input  logic                 isa_mode,
    input  logic                 user_en,
    input  logic                 priv_en,
    input  logic                 frozen,
    input  logic [EVT_W-1:0]     evt,
    output logic                 cnt_en_o,
    output logic [CNT_W-1:0]     inc_o
);

    logic mon_en;
    logic above;

    assign mon_en   = priv_mode ? priv_en : user_en;
    assign cnt_en_o = lvl_allows(lvl_mask, cur_lvl) & isa_allows(isa_mask, isa_mode)
                      & mon_en & ~frozen;
    assign above    = evt > EVT_W'(thr);

    always_comb begin
        if (thr == '0) begin
            inc_o = CNT_W'(evt);
        end else begin
            inc_o = CNT_W'(above);
        end
    end

endmodule

// File: rtl/pmc_accum.sv
module pmc_accum #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             cnt_en,
    input  logic [CNT_W-1:0] inc,
    input  logic             irq_en,
    input  logic             strobe_en,
    input  logic             frz_we,
    input  logic             frz_wdata,
    output logic [CNT_W-1:0] count_o,
    output logic             freeze_o,
    output logic             irq_o,
    output logic             strobe_o
);

    logic [CNT_W:0] sum;
    logic           wrap;

    assign sum  = {1'b0, count_o} + {1'b0, inc};
    assign wrap = cnt_en & ~load & sum[CNT_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            count_o  <= '0;
            freeze_o <= 1'b0;
            irq_o    <= 1'b0;
            strobe_o <= 1'b0;
        end else begin
            irq_o    <= wrap & irq_en;
            strobe_o <= wrap & strobe_en;
            if (load) begin
                count_o <= load_val;
            end else if (cnt_en) begin
                count_o <= sum[CNT_W-1:0];
            end
            if (wrap & irq_en) begin
                freeze_o <= 1'b1;
            end else if (frz_we) begin
                freeze_o <= frz_wdata;
            end
        end
    end

    // R7: an interrupt pulse is always accompanied by the freeze bit
    a_r7_irq_freezes: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> freeze_o);

    // R7: one overflow gives one pulse only
    a_r7_single_irq: assert property (@(posedge clk) disable iff (rst)
        irq_o |=> !irq_o);

    // R8: a strobe only follows a cycle with the strobe enable set
    a_r8_strobe_enabled: assert property (@(posedge clk) disable iff (rst)
        strobe_o |-> $past(strobe_en));

    // R9: frozen count holds unless software loads it
    a_r9_frozen_holds: assert property (@(posedge clk) disable iff (rst)
        (freeze_o && !load) |=> $stable(count_o));

    // R10: a load lands at the next edge
    a_r10_load_value: assert property (@(posedge clk) disable iff (rst)
        load |=> (count_o == $past(load_val)));

endmodule

// File: rtl/pmc_counter.sv
module pmc_counter
    import pmc_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int EVT_W = 4,
    parameter int THR_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [31:0]      cfg_wdata,
    output logic [31:0]      cfg_rdata,
    input  logic             cnt_we,
    input  logic [CNT_W-1:0] cnt_wdata,
    input  logic             cnt_re,
    output logic [CNT_W-1:0] cnt_rdata,
    output logic             rd_fault,
    input  logic             frz_we,
    input  logic             frz_wdata,
    input  logic [EVT_W-1:0] evt_val,
    input  logic [1:0]       cur_lvl,
    input  logic             isa_mode,
    input  logic             user_en,
    input  logic             priv_en,
    output logic             freeze,
    output logic             ovf_irq,
    output logic             ext_strobe
);

    pmc_cfg_t         cfg_q;
    logic             cnt_en;
    logic [CNT_W-1:0] inc;
    logic [CNT_W-1:0] count_q;
    logic             rd_block;

    pmc_cfg_reg #(.THR_W(THR_W)) u_cfg (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .cfg_o (cfg_q)
    );

    pmc_gate #(.CNT_W(CNT_W), .EVT_W(EVT_W)) u_gate (
        .lvl_mask  (cfg_q.lvl_mask),
        .isa_mask  (cfg_q.isa_mask),
        .priv_mode (cfg_q.priv_mode),
        .thr       (cfg_q.thr),
        .cur_lvl   (cur_lvl),
        .isa_mode  (isa_mode),
        .user_en   (user_en),
        .priv_en   (priv_en),
        .frozen    (freeze),
        .evt       (evt_val),
        .cnt_en_o  (cnt_en),
        .inc_o     (inc)
    );

    pmc_accum #(.CNT_W(CNT_W)) u_accum (
        .clk       (clk),
        .rst       (rst),
        .load      (cnt_we),
        .load_val  (cnt_wdata),
        .cnt_en    (cnt_en),
        .inc       (inc),
        .irq_en    (cfg_q.irq_en),
        .strobe_en (cfg_q.strobe_en),
        .frz_we    (frz_we),
        .frz_wdata (frz_wdata),
        .count_o   (count_q),
        .freeze_o  (freeze),
        .irq_o     (ovf_irq),
        .strobe_o  (ext_strobe)
    );

    assign cfg_rdata = pack_cfg(cfg_q);
    assign rd_block  = cfg_q.priv_mode & (cur_lvl != 2'd0);
    assign cnt_rdata = rd_block ? '0 : count_q;
    assign rd_fault  = cnt_re & rd_block;

    // R2: an all-zero level mask never counts
    a_r2_no_level: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.lvl_mask == '0 && !cnt_we) |=> $stable(count_q));

    // R3: mode mask 11 never counts
    a_r3_isa_off: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.isa_mask == 2'b11 && !cnt_we) |=> $stable(count_q));

    // R4: user monitor without its enable never counts
    a_r4_user_gate: assert property (@(posedge clk) disable iff (rst)
        (!cfg_q.priv_mode && !user_en && !cnt_we) |=> $stable(count_q));

    // R11: a denied read returns zero
    a_r11_fault_zero: assert property (@(posedge clk) disable iff (rst)
        rd_fault |-> (cnt_rdata == '0));

endmodule

// File: tb/pmc_counter_test.sv
module pmc_counter_test;

    localparam int THR_W = 3;
    localparam logic [31:0] CFG_MASK = 32'h0300_7F7F | (((32'd1 << THR_W) - 32'd1) << 20);

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        cnt_we = 1'b0;
    logic [31:0] cnt_wdata = '0;
    logic        cnt_re = 1'b0;
    logic [31:0] cnt_rdata;
    logic        rd_fault;
    logic        frz_we = 1'b0;
    logic        frz_wdata = 1'b0;
    logic [3:0]  evt_val = '0;
    logic [1:0]  cur_lvl = '0;
    logic        isa_mode = 1'b0;
    logic        user_en = 1'b0;
    logic        priv_en = 1'b0;
    logic        freeze;
    logic        ovf_irq;
    logic        ext_strobe;

    int    checks = 0;
    int    errors = 0;
    int    cycles = 0;
    string req = "R1";

    always #4 clk = ~clk;

    pmc_counter #(.CNT_W(32), .EVT_W(4), .THR_W(THR_W)) uut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .cnt_we(cnt_we), .cnt_wdata(cnt_wdata), .cnt_re(cnt_re), .cnt_rdata(cnt_rdata),
        .rd_fault(rd_fault), .frz_we(frz_we), .frz_wdata(frz_wdata), .evt_val(evt_val),
        .cur_lvl(cur_lvl), .isa_mode(isa_mode), .user_en(user_en), .priv_en(priv_en),
        .freeze(freeze), .ovf_irq(ovf_irq), .ext_strobe(ext_strobe)
    );

    // Behavioural reference model
    logic [31:0] m_cfg, m_cnt, m_inc;
    logic        m_frz, m_irq, m_stb, m_en, m_wrap;
    logic [32:0] m_sum;
    int          m_thr;

    always @(posedge clk) begin
        if (rst) begin
            m_cfg = '0; m_cnt = '0; m_frz = 0; m_irq = 0; m_stb = 0;
        end else begin
            m_thr = int'((m_cfg >> 20) & 32'd7);
            m_en  = m_cfg[cur_lvl] && (isa_mode ? !m_cfg[25] : !m_cfg[24])
                    && (m_cfg[6] ? priv_en : user_en) && !m_frz;
            if (m_thr == 0) m_inc = {28'd0, evt_val};
            else            m_inc = (int'(evt_val) > m_thr) ? 32'd1 : 32'd0;
            m_wrap = 1'b0;
            if (cnt_we) begin
                m_cnt = cnt_wdata;
            end else if (m_en) begin
                m_sum  = {1'b0, m_cnt} + {1'b0, m_inc};
                m_wrap = m_sum[32];
                m_cnt  = m_sum[31:0];
            end
            m_irq = m_wrap && m_cfg[5];
            m_stb = m_wrap && m_cfg[4];
            if (m_irq) m_frz = 1'b1;
            else if (frz_we) m_frz = frz_wdata;
            if (cfg_we) m_cfg = cfg_wdata & CFG_MASK;
        end
    end

    task automatic check1(input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic compare();
        logic blk;
        blk = m_cfg[6] && (cur_lvl != 2'd0);
        check1("cnt_rdata", cnt_rdata, blk ? 32'd0 : m_cnt);
        check1("rd_fault", {31'd0, rd_fault}, {31'd0, cnt_re && blk});
        check1("freeze", {31'd0, freeze}, {31'd0, m_frz});
        check1("ovf_irq", {31'd0, ovf_irq}, {31'd0, m_irq});
        check1("ext_strobe", {31'd0, ext_strobe}, {31'd0, m_stb});
        check1("cfg_rdata", cfg_rdata, m_cfg);
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
        cycles++;
        compare();
    endtask

    function automatic logic [31:0] mk(input logic [3:0] lvl, input logic stb, input logic irq,
                                       input logic pm, input logic [2:0] thr, input logic [1:0] isa);
        return {6'd0, isa, 1'b0, thr, 5'd0, 7'h15, 1'b0, pm, irq, stb, lvl};
    endfunction

    task automatic wr_cfg(input logic [31:0] v);
        cfg_we = 1; cfg_wdata = v; cyc(); cfg_we = 0;
    endtask

    task automatic load(input logic [31:0] v);
        cnt_we = 1; cnt_wdata = v; cyc(); cnt_we = 0;
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL R1 watchdog actual %0d cycles expected completion", cycles);
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        req = "R1"; compare();
        cyc();

        // R5: summing mode over every event value
        req = "R5"; user_en = 1;
        wr_cfg(mk(4'hF, 0, 0, 0, 3'd0, 2'b00));
        for (int i = 0; i < 16; i++) begin evt_val = 4'(i); cyc(); end

        // R6: threshold mode, strict compare
        req = "R6";
        wr_cfg(mk(4'hF, 0, 0, 0, 3'd5, 2'b00));
        evt_val = 5;  cyc();
        evt_val = 6;  cyc();
        evt_val = 15; cyc();
        evt_val = 0;  cyc();
        evt_val = 4;  cyc();

        // R2: level mask
        req = "R2"; evt_val = 1;
        wr_cfg(mk(4'b0100, 0, 0, 0, 3'd0, 2'b00));
        for (int l = 0; l < 4; l++) begin cur_lvl = 2'(l); cyc(); end
        wr_cfg(mk(4'b0000, 0, 0, 0, 3'd0, 2'b00));
        cur_lvl = 2; cyc(); cyc();
        cur_lvl = 0;

        // R3: mode mask codes in both modes
        req = "R3"; evt_val = 2;
        for (int c = 0; c < 4; c++) begin
            wr_cfg(mk(4'hF, 0, 0, 0, 3'd0, 2'(c)));
            isa_mode = 0; cyc();
            isa_mode = 1; cyc();
        end
        isa_mode = 0;

        // R4: enable selection by the mode bit
        req = "R4";
        for (int p = 0; p < 2; p++) begin
            wr_cfg(mk(4'hF, 0, 0, p[0], 3'd0, 2'b00));
            for (int e = 0; e < 4; e++) begin
                user_en = e[0]; priv_en = e[1]; cyc();
            end
        end
        user_en = 1; priv_en = 0;

        // R10: load beats counting
        req = "R10";
        wr_cfg(mk(4'hF, 0, 1, 0, 3'd0, 2'b00));
        evt_val = 3;
        load(32'hFFFF_FFF0);
        cyc();

        // R7: interrupting wrap and R9 hold while frozen
        req = "R7"; evt_val = 15;
        load(32'hFFFF_FFF0);
        cyc(); cyc(); cyc();
        req = "R9";
        cyc(); cyc();
        frz_we = 1; frz_wdata = 0; cyc(); frz_we = 0;
        cyc(); cyc();
        frz_we = 1; frz_wdata = 1; cyc(); frz_we = 0;
        cyc();
        frz_we = 1; frz_wdata = 0; cyc(); frz_we = 0;

        // R7: wrap with interrupt disabled leaves freeze alone
        req = "R7";
        wr_cfg(mk(4'hF, 0, 0, 0, 3'd0, 2'b00));
        load(32'hFFFF_FFFE);
        cyc(); cyc();

        // R8: strobe alone, then with interrupt
        req = "R8";
        wr_cfg(mk(4'hF, 1, 0, 0, 3'd0, 2'b00));
        load(32'hFFFF_FFFE);
        cyc(); cyc(); cyc();
        wr_cfg(mk(4'hF, 1, 1, 0, 3'd0, 2'b00));
        load(32'hFFFF_FFFE);
        cyc(); cyc();

        // R9: overflow wins over a same-cycle clear
        req = "R9";
        frz_we = 1; frz_wdata = 0; cyc(); frz_we = 0;
        load(32'hFFFF_FFF8);
        frz_we = 1; frz_wdata = 0; cyc(); frz_we = 0;
        cyc(); cyc();
        frz_we = 1; frz_wdata = 0; cyc(); frz_we = 0;

        // R11: protected reads
        req = "R11"; evt_val = 1; priv_en = 1; cnt_re = 1;
        wr_cfg(mk(4'hF, 0, 0, 1, 3'd0, 2'b00));
        for (int l = 0; l < 4; l++) begin cur_lvl = 2'(l); cyc(); end
        cnt_re = 0; cur_lvl = 3; cyc();
        wr_cfg(mk(4'hF, 0, 0, 0, 3'd0, 2'b00));
        cnt_re = 1; cyc(); cnt_re = 0; cur_lvl = 0;

        // R12: readback of stored fields only
        req = "R12"; evt_val = 0;
        wr_cfg(32'hFFFF_FFFF);
        cyc();
        wr_cfg(32'hA5A5_5A5A);
        cyc();
        wr_cfg(32'h0);
        cyc();

        finish_run();
    end

endmodule